// File: doc/BRIEF.md
# Clock-Sampled Asynchronous DRAM Model

This block is a synthesizable stand-in for a small asynchronous DRAM. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and the 10-bit multiplexed address. Each strobe's sample is compared with its value one clock earlier to find edges. The order in which the edges arrive decides what kind of cycle is running. The block then carries out that cycle on an internal byte array and drives a data bus that has a separate drive-enable.

Cycles are never given by a command. The block infers each one from the strobes:

- a plain row refresh;
- a refresh with column-before-row order, which uses an internal 10-bit row counter;
- a hidden refresh that runs under a held read;
- an early write;
- a late write or read-modify-write;
- a read;
- fast page cycles, which are several column accesses under a single row-strobe low period.

A 3-bit cycle code and the row touched by the most recent row-strobe fall are brought out so that a checker can see what the block decided. A one-cycle pulse flags two kinds of misuse: a column strobe that falls on the same sample in which the open row is released, and an access made before eight row-strobe cycles have followed reset.

The strobes carry their own protocol, so the pins stay plain. No valid/ready handshake is used and no back-pressure is possible.

Top module: `dram_strobe_model`

## Requirements
- R1: In every cycle where both the row and column strobes were high at the last clock edge, `dout_en` is 0 and `cyc_type` is 0 (standby).
- R2: If the column strobe is low when the row strobe falls, the cycle is a refresh from the counter, with code 5. `last_row` takes the internal counter value and the address pins are ignored. The counter is 0 after reset and advances by one, modulo 1024, per such refresh. The output stays off.
- R3: If the row strobe falls while the column strobe is high, code 4 (row-only refresh) is shown, `last_row` takes the address, and the output stays off. If no column strobe follows, the cycle stays code 4 until standby.
- R4: If write enable is low when the column strobe falls, the cycle is an early write with code 2. `din` is stored at byte index {row[ROW_BITS-1:0], column[COL_BITS-1:0]}, and the output stays off for the whole cycle.
- R5: If write enable is high when the column strobe falls, the cycle is a read with code 1. The byte at that index is captured and is driven on `dout` with `dout_en` high while output enable is low.
- R6: If write enable falls while the column strobe is low during a read, the cycle becomes code 3 and `din` is stored at that column. From then on the byte offered on `dout` is the new one: it is driven at once if output enable is low, and it appears if output enable is taken low again.
- R7: `dout_en` drops when output enable is high or when the column strobe rises, and it comes back if output enable goes low again while the read column is still held.
- R8: If the column strobe is held low after a read while the row strobe rises and falls again, the new fall is a hidden refresh with code 6. It uses and advances the counter, and the read byte stays driven throughout.
- R9: Several column strobe pulses under one row-strobe low period each access a new column of the same row (fast page).
- R10: `proto_err` is high for exactly one cycle in two cases. The first is when, with a row open and no column active, the column strobe falls in the same sample in which the row strobe rises. The second is when a column access starts before WAKE_CYCLES (8) row-strobe falls have been seen since reset.
- R11: Every output responds at the first rising clock edge at which the changed input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Drive enable for `dout` |
| cyc_type | output | 3 | Cycle code: 0 standby, 1 read, 2 early write, 3 late write/RMW, 4 row-only refresh, 5 counter refresh, 6 hidden refresh |
| last_row | output | 10 | Row used by the latest row-strobe fall |
| proto_err | output | 1 | One-cycle misuse pulse |

## Verification
Each result is registered exactly once. A strobe change that is driven before a rising edge therefore shows on the outputs right after that edge: the cycle code, the drive-enable, the read byte, the refresh row and the error pulse all appear together. The bench changes inputs only at falling clock edges and samples the outputs 1 ns after the next rising edge. Every expectation is tied to the single edge that should produce it. In a late write, the old byte is checked one edge before the new one. For a hidden refresh, the drive-enable is checked at each of the row-strobe edges in between.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    CYC_STANDBY  = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RAS_ONLY = 3'd4,
    CYC_CBR      = 3'd5,
    CYC_HIDDEN   = 3'd6
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE, // row strobe high, no data held
    ST_ROW,  // row open, column strobe high
    ST_COL,  // row open, column access running
    ST_CBR,  // counter refresh in progress
    ST_HOLD  // row strobe high, column strobe still low from a read
  } st_e;
endpackage

// File: rtl/dram_edge_sampler.sv
module dram_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic oe_n,
  output logic ras_lvl,
  output logic cas_lvl,
  output logic oe_lvl,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cas_rise,
  output logic we_fall
);
  logic we_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lvl <= 1'b1;
      cas_lvl <= 1'b1;
      we_lvl  <= 1'b1;
      oe_lvl  <= 1'b1;
    end else begin
      ras_lvl <= ras_n;
      cas_lvl <= cas_n;
      we_lvl  <= we_n;
      oe_lvl  <= oe_n;
    end
  end

  // Edges compare the current sample with the previous one.
  assign ras_fall = ras_lvl & ~ras_n;
  assign ras_rise = ~ras_lvl & ras_n;
  assign cas_fall = cas_lvl & ~cas_n;
  assign cas_rise = ~cas_lvl & cas_n;
  assign we_fall  = we_lvl & ~we_n;
endmodule

// File: rtl/dram_byte_array.sv
module dram_byte_array #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int ROW_BITS    = 3,
  parameter int COL_BITS    = 3,
  parameter int WAKE_CYCLES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic                         oe_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            din,
  input  logic                         ras_fall,
  input  logic                         ras_rise,
  input  logic                         cas_fall,
  input  logic                         cas_rise,
  input  logic                         we_fall,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic                         mem_we,
  output logic [ROW_BITS+COL_BITS-1:0] mem_idx,
  output logic [DATA_W-1:0]            mem_wdata,
  output logic [DATA_W-1:0]            dout,
  output logic                         dout_en,
  output logic [2:0]                   cyc_type,
  output logic [ADDR_W-1:0]            last_row,
  output logic                         proto_err
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  st_e                  st_q, st_n;
  cyc_e                 typ_q, typ_n;
  logic                 vld_q, vld_n;
  logic [DATA_W-1:0]    dat_q, dat_n;
  logic [ROW_BITS-1:0]  row_q, row_n;
  logic [COL_BITS-1:0]  col_q, col_n;
  logic [ADDR_W-1:0]    cnt_q, cnt_n;
  logic [ADDR_W-1:0]    last_q, last_n;
  logic [WAKE_W-1:0]    wake_q, wake_n;
  logic                 err_q, err_n;
  logic                 en_q;
  logic                 woke;
  logic                 cnt_refresh;

  assign woke = (wake_q >= WAKE_W'(WAKE_CYCLES));

  always_comb begin
    st_n        = st_q;
    typ_n       = typ_q;
    vld_n       = vld_q;
    dat_n       = dat_q;
    row_n       = row_q;
    col_n       = col_q;
    cnt_n       = cnt_q;
    last_n      = last_q;
    wake_n      = wake_q;
    err_n       = 1'b0;
    mem_we      = 1'b0;
    mem_wdata   = din;
    mem_idx     = {row_q, addr[COL_BITS-1:0]};
    cnt_refresh = 1'b0;

    if (ras_fall && !woke) wake_n = wake_q + WAKE_W'(1);

    unique case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (ras_fall && !cas_n) begin
          st_n        = ST_CBR;
          typ_n       = (st_q == ST_HOLD) ? CYC_HIDDEN : CYC_CBR;
          last_n      = cnt_q;
          cnt_n       = cnt_q + ADDR_W'(1);
          cnt_refresh = 1'b1;
        end else if (ras_fall) begin
          st_n   = ST_ROW;
          typ_n  = CYC_RAS_ONLY;
          row_n  = addr[ROW_BITS-1:0];
          last_n = addr;
        end else if (st_q == ST_HOLD && cas_rise) begin
          st_n = ST_IDLE;
        end
      end
      ST_ROW: begin
        if (ras_rise) begin
          st_n = ST_IDLE;
          if (cas_fall) err_n = 1'b1;
        end else if (cas_fall) begin
          st_n  = ST_COL;
          col_n = addr[COL_BITS-1:0];
          if (!woke) err_n = 1'b1;
          if (!we_n) begin
            mem_we = 1'b1;
            typ_n  = CYC_EARLY_WR;
            vld_n  = 1'b0;
          end else begin
            typ_n = CYC_READ;
            vld_n = 1'b1;
            dat_n = mem_rdata;
          end
        end
      end
      ST_COL: begin
        mem_idx = {row_q, col_q};
        if (we_fall && !cas_n && !ras_n && typ_q != CYC_EARLY_WR) begin
          mem_we = 1'b1;
          typ_n  = CYC_LATE_WR;
          dat_n  = din;
        end
        if (ras_rise && cas_rise) st_n = ST_IDLE;
        else if (cas_rise)        st_n = ST_ROW;
        else if (ras_rise)        st_n = ST_HOLD;
      end
      ST_CBR: begin
        if (ras_rise) st_n = (vld_q && !cas_n) ? ST_HOLD : ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase

    if (cas_n) vld_n = 1'b0;
    if (ras_n && cas_n) typ_n = CYC_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      typ_q  <= CYC_STANDBY;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      wake_q <= '0;
      err_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      typ_q  <= typ_n;
      vld_q  <= vld_n;
      dat_q  <= dat_n;
      row_q  <= row_n;
      col_q  <= col_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
      wake_q <= wake_n;
      err_q  <= err_n;
      en_q   <= vld_n & ~oe_n;
    end
  end

  assign dout      = en_q ? dat_q : '0;
  assign dout_en   = en_q;
  assign cyc_type  = typ_q;
  assign last_row  = last_q;
  assign proto_err = err_q;

  // R2: each counter refresh moves the counter on by exactly one
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_refresh |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));

  // R4: an early write never drives the bus
  assert_early_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (typ_q == CYC_EARLY_WR) |-> !en_q);

  // R10: the misuse flag is a single-cycle pulse
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  // R2: a plain counter refresh leaves the bus undriven
  assert_cbr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (typ_q == CYC_CBR) |-> !en_q);
endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int ROW_BITS    = 3,
  parameter int COL_BITS    = 3,
  parameter int WAKE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [2:0]        cyc_type,
  output logic [ADDR_W-1:0] last_row,
  output logic              proto_err
);
  localparam int IDX_W = ROW_BITS + COL_BITS;

  logic ras_lvl, cas_lvl, oe_lvl;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  dram_edge_sampler u_sampler (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .ras_lvl(ras_lvl), .cas_lvl(cas_lvl), .oe_lvl(oe_lvl),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
  );

  dram_byte_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .wr_en(mem_we), .idx(mem_idx),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  dram_cycle_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata),
    .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
    .last_row(last_row), .proto_err(proto_err)
  );

  // R1: both strobes high at the last edge means standby with the bus off
  assert_standby_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_lvl && cas_lvl) |-> (!dout_en && cyc_type == 3'd0));

  // R7: output enable high at the last edge means the bus is off
  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_lvl |-> !dout_en);
endmodule

// File: tb/dram_strobe_model_test.sv
module dram_strobe_model_test;
  localparam int RB = 3;
  localparam int CB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  logic [2:0] cyc_type;
  logic [9:0] last_row;
  logic proto_err;

  int checks = 0;
  int errors = 0;
  int ref_exp = 0;
  logic [7:0] mem_m [64];

  always #4 clk = ~clk;

  dram_strobe_model uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
    .last_row(last_row), .proto_err(proto_err)
  );

  function automatic int idx_of(int row, int col);
    return ((row & ((1 << RB) - 1)) << CB) | (col & ((1 << CB) - 1));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic c, logic w, logic o, int a, int d);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    addr = a[9:0]; din = d[7:0];
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    ref_exp = 0;
  endtask

  task automatic ras_only(int row);
    step(0, 1, 1, 1, row, 0);
    check("R3 row-only code", cyc_type, 4);
    check("R3 row latched", last_row, row & 10'h3ff);
    check("R3 output off", dout_en, 0);
    step(1, 1, 1, 1, 0, 0);
    check("R1 standby code", cyc_type, 0);
    check("R1 standby off", dout_en, 0);
  endtask

  task automatic early_wr(int row, int col, int data);
    step(0, 1, 1, 1, row, 0);
    step(0, 0, 0, 0, col, data);
    check("R4 early code", cyc_type, 2);
    check("R4 output off", dout_en, 0);
    step(0, 1, 1, 0, col, 0);
    check("R4 output still off", dout_en, 0);
    step(1, 1, 1, 1, 0, 0);
    mem_m[idx_of(row, col)] = data[7:0];
  endtask

  task automatic read_chk(int row, int col);
    int exp = mem_m[idx_of(row, col)];
    step(0, 1, 1, 0, row, 0);
    check("R11 code after first edge", cyc_type, 4);
    step(0, 0, 1, 0, col, 0);
    check("R5 read code", cyc_type, 1);
    check("R5 driven", dout_en, 1);
    check("R5 read data", dout, exp);
    step(0, 0, 1, 1, col, 0);
    check("R7 oe high off", dout_en, 0);
    step(0, 0, 1, 0, col, 0);
    check("R7 oe low again", dout_en, 1);
    check("R7 data again", dout, exp);
    step(1, 1, 1, 0, 0, 0);
    check("R1 end off", dout_en, 0);
    check("R1 end code", cyc_type, 0);
  endtask

  task automatic late_wr(int row, int col, int data, bit rmw);
    int old = mem_m[idx_of(row, col)];
    step(0, 1, 1, 0, row, 0);
    step(0, 0, 1, 0, col, 0);
    check("R6 old data first", dout, old);
    if (rmw) begin
      step(0, 0, 0, 0, col, data);
      check("R6 late code", cyc_type, 3);
      check("R6 new data driven", dout, data & 8'hff);
      check("R6 still driven", dout_en, 1);
    end else begin
      step(0, 0, 1, 1, col, 0);
      step(0, 0, 0, 1, col, data);
      check("R6 late code", cyc_type, 3);
      check("R6 off with oe high", dout_en, 0);
    end
    step(1, 1, 1, 1, 0, 0);
    mem_m[idx_of(row, col)] = data[7:0];
  endtask

  task automatic page_rd(int row);
    step(0, 1, 1, 0, row, 0);
    for (int k = 0; k < 3; k++) begin
      int col = (k * 3 + 1) & 7;
      step(0, 0, 1, 0, col, 0);
      check("R9 page code", cyc_type, 1);
      check("R9 page data", dout, mem_m[idx_of(row, col)]);
      step(0, 1, 1, 0, col, 0);
      check("R7 cas high off", dout_en, 0);
    end
    step(1, 1, 1, 1, 0, 0);
  endtask

  task automatic cbr(int junk);
    step(1, 0, 1, 1, junk, 0);
    step(0, 0, 1, 1, junk, 0);
    check("R2 counter code", cyc_type, 5);
    check("R2 counter row", last_row, ref_exp);
    check("R2 output off", dout_en, 0);
    ref_exp = (ref_exp + 1) & 10'h3ff;
    step(1, 0, 1, 1, junk, 0);
    step(1, 1, 1, 1, 0, 0);
    check("R1 after refresh", cyc_type, 0);
  endtask

  task automatic hidden(int row, int col);
    int exp = mem_m[idx_of(row, col)];
    step(0, 1, 1, 0, row, 0);
    step(0, 0, 1, 0, col, 0);
    check("R8 read before", dout, exp);
    step(1, 0, 1, 0, 10'h2aa, 0);
    check("R8 held through rise", dout_en, 1);
    step(0, 0, 1, 0, 10'h155, 0);
    check("R8 hidden code", cyc_type, 6);
    check("R8 counter row", last_row, ref_exp);
    check("R8 still driven", dout_en, 1);
    check("R8 data kept", dout, exp);
    ref_exp = (ref_exp + 1) & 10'h3ff;
    step(1, 0, 1, 0, 0, 0);
    check("R8 held after", dout_en, 1);
    step(1, 1, 1, 0, 0, 0);
    check("R1 hidden end", dout_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;
    do_reset();
    check("R1 reset off", dout_en, 0);
    check("R1 reset code", cyc_type, 0);
    check("R10 reset no err", proto_err, 0);

    // R10: access too soon after reset
    step(0, 1, 1, 1, 5, 0);
    step(0, 0, 1, 1, 3, 0);
    check("R10 wake err", proto_err, 1);
    step(0, 0, 1, 1, 3, 0);
    check("R10 pulse ends", proto_err, 0);
    step(1, 1, 1, 1, 0, 0);

    do_reset();
    for (int i = 0; i < 8; i++) ras_only(i * 37 + 3);

    for (int i = 0; i < 8; i++) early_wr(i, 7 - i, 8'h10 + i);
    for (int i = 0; i < 8; i++) early_wr(2, i, 8'h40 + i * 3);
    check("R10 no err after wake", proto_err, 0);
    read_chk(2, 5);
    read_chk(6, 1);
    late_wr(3, 4, 8'hc3, 1'b0);
    read_chk(3, 4);
    late_wr(5, 2, 8'h7e, 1'b1);
    read_chk(5, 2);
    page_rd(2);
    cbr(10'h3ff);
    cbr(10'h011);
    hidden(2, 5);
    cbr(10'h200);

    // R10: column strobe falls as the open row is released
    step(0, 1, 1, 1, 4, 0);
    step(1, 0, 1, 1, 4, 0);
    check("R10 coincident edge err", proto_err, 1);
    step(1, 1, 1, 1, 0, 0);
    check("R10 pulse ends", proto_err, 0);

    for (int n = 0; n < 60; n++) begin
      int op = $urandom % 5;
      int row = $urandom % 1024;
      int col = $urandom % 1024;
      int dat = $urandom % 256;
      case (op)
        0: early_wr(row, col, dat);
        1: read_chk(row, col);
        2: late_wr(row, col, dat, dat[0]);
        3: cbr(row);
        default: hidden(row, col);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule